// File: doc/BRIEF.md
# Signed-Magnitude Adder/Subtractor

This is a combinational arithmetic unit for operands held in sign-and-magnitude form. The top bit of each operand carries the sign and the remaining bits carry an unsigned magnitude. A single control input selects between A + B and A − B. Subtraction is done by inverting the sign of B and then adding. The add is not a two's-complement add. The unit compares the effective signs and the magnitudes, and from that it decides whether to add or subtract magnitudes and which sign the result takes.

The outputs are the result in the same format, an overflow flag and a zero flag. Both encodings of zero are accepted on the inputs. A zero result always leaves as positive zero. The width is a parameter with a default of 8 bits.

Top module: `sm_addsub`

## Requirements
- R1: Bit W-1 of every operand and of the result is the sign (0 = positive, 1 = negative), and bits W-2..0 are an unsigned magnitude. For any in-range inputs whose true result fits in W-1 magnitude bits, `res` encodes that true sum or difference.
- R2: With `sub` = 1, the result equals A + (−B). Negating B only inverts its sign bit and leaves its magnitude unchanged.
- R3: When the sign of A equals the effective sign of B, the result magnitude is the sum of the magnitudes and the result sign is that common sign.
- R4: When the effective signs differ, the result magnitude is the larger magnitude minus the smaller one, and the result sign is the sign of the operand with the larger magnitude.
- R5: `ovf` is 1 only when same-sign magnitudes are added and the sum does not fit in W-1 bits. The result magnitude is then the low W-1 bits of the sum. `ovf` is always 0 when the effective signs differ.
- R6: Any result with a zero magnitude is output with sign bit 0, and `zero` is 1 exactly when the result magnitude is 0.
- R7: An operand with the sign bit set and a zero magnitude behaves as zero: it adds to the other operand without changing its value.
- R8: Operands with equal magnitudes and differing effective signs give positive zero with `ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand, sign-magnitude |
| b | input | W | Second operand, sign-magnitude |
| sub | input | 1 | 0 selects A + B, 1 selects A − B |
| res | output | W | Result, sign-magnitude |
| ovf | output | 1 | Magnitude overflow on same-sign add |
| zero | output | 1 | Result magnitude is zero |

## Verification
The bench builds two copies of the unit. One uses the default width of 8 and runs directed cases: overflow at the top of the range, the wrap to a zero magnitude when 64 + 64 overflows, negative-zero operands, and equal-magnitude cancellation. The other uses a width of 4, which makes it possible to sweep every pair of operands in both modes. That sweep covers both zero encodings, every sign combination and every point where the magnitude comparison flips.

// File: rtl/sm_addsub.sv
module sm_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         ovf,
  output logic         zero
);
  localparam int MW = W - 1;

  logic          sa, sb;
  logic [MW-1:0] ma, mb;
  logic          same_sign;
  logic          a_ge_b;
  logic [MW:0]   mag_sum;
  logic [MW-1:0] mag_diff;
  logic [MW-1:0] mag;
  logic          sign_raw;

  assign sa = a[W-1];
  assign sb = b[W-1] ^ sub;
  assign ma = a[MW-1:0];
  assign mb = b[MW-1:0];

  assign same_sign = (sa == sb);
  assign a_ge_b    = (ma >= mb);
  assign mag_sum   = {1'b0, ma} + {1'b0, mb};
  assign mag_diff  = a_ge_b ? (ma - mb) : (mb - ma);

  assign mag      = same_sign ? mag_sum[MW-1:0] : mag_diff;
  assign sign_raw = same_sign ? sa : (a_ge_b ? sa : sb);

  assign ovf  = same_sign & mag_sum[MW];
  assign zero = (mag == '0);
  assign res  = {sign_raw & ~zero, mag};

  always_comb begin
    if (zero) AST_ZERO_POSITIVE: assert (res[W-1] == 1'b0); // R6
    if (ovf) AST_OVF_SAME_SIGN: assert (a[W-1] == (b[W-1] ^ sub)); // R5
    if ((a[W-1] != (b[W-1] ^ sub)) && (a[MW-1:0] == b[MW-1:0]))
      AST_CANCEL_TO_ZERO: assert (res == '0 && !ovf); // R8
    if ((a[W-1] == (b[W-1] ^ sub)) && (res[MW-1:0] != '0))
      AST_COMMON_SIGN: assert (res[W-1] == a[W-1]); // R3
    if (a[W-1] != (b[W-1] ^ sub))
      AST_DIFF_BOUNDED: assert (res[MW-1:0] <= a[MW-1:0] || res[MW-1:0] <= b[MW-1:0]); // R4
  end
endmodule

// File: tb/sim_sm_addsub.sv
`timescale 1ns/1ps
module sim_sm_addsub;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [7:0] y;
    logic       ovf;
    logic       zero;
    logic [7:0] a, b;
    logic       sub;
    string      tag;
  } exp_t;

  exp_t q8[$];
  exp_t q4[$];
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] a8, b8, r8;
  logic       s8, o8, z8;
  logic [3:0] a4, b4, r4;
  logic       s4, o4, z4;

  sm_addsub #(.W(8)) u0 (.a(a8), .b(b8), .sub(s8), .res(r8), .ovf(o8), .zero(z8));
  sm_addsub #(.W(4)) u1 (.a(a4), .b(b4), .sub(s4), .res(r4), .ovf(o4), .zero(z4));

  function automatic exp_t model(int w, int a, int b, bit s, string tag);
    exp_t e;
    int half = 1 << (w - 1);
    int va = ((a >> (w - 1)) & 1) ? -(a % half) : (a % half);
    int vb = ((b >> (w - 1)) & 1) ? -(b % half) : (b % half);
    int r, ar, m;
    if (s) vb = -vb;
    r  = va + vb;
    ar = (r < 0) ? -r : r;
    m  = ar % half;
    e.ovf  = (ar >= half);
    e.zero = (m == 0);
    e.y    = 8'(((r < 0 && m != 0) ? half : 0) + m);
    e.a = 8'(a); e.b = 8'(b); e.sub = s; e.tag = tag;
    return e;
  endfunction

  task automatic drive8(input logic [7:0] a, input logic [7:0] b, input bit s, input string tag);
    @(posedge clk); #1;
    a8 = a; b8 = b; s8 = s;
    q8.push_back(model(8, int'(a), int'(b), s, tag));
  endtask

  task automatic drive4(input logic [3:0] a, input logic [3:0] b, input bit s, input string tag);
    @(posedge clk); #1;
    a4 = a; b4 = b; s4 = s;
    q4.push_back(model(4, int'(a), int'(b), s, tag));
  endtask

  task automatic compare(input exp_t e, input logic [7:0] y, input logic o, input logic z, input int w);
    tests++;
    if (y !== e.y || o !== e.ovf || z !== e.zero) begin
      fails++;
      $display("FAIL %s W=%0d a=%h b=%h sub=%0b: got res=%h ovf=%0b zero=%0b expected res=%h ovf=%0b zero=%0b",
               e.tag, w, e.a, e.b, e.sub, y, o, z, e.y, e.ovf, e.zero);
    end
  endtask

  always @(negedge clk) begin
    if (q8.size() > 0) compare(q8.pop_front(), r8, o8, z8, 8);
    if (q4.size() > 0) compare(q4.pop_front(), {4'h0, r4}, o4, z4, 4);
  end

  initial begin
    a8 = '0; b8 = '0; s8 = 1'b0;
    a4 = '0; b4 = '0; s4 = 1'b0;
    drive8(8'h00, 8'h00, 0, "R6");
    drive8(8'h05, 8'h03, 0, "R1");
    drive8(8'h85, 8'h83, 0, "R3");
    drive8(8'h05, 8'h89, 0, "R4");
    drive8(8'h8C, 8'h03, 0, "R4");
    drive8(8'h09, 8'h05, 1, "R2");
    drive8(8'h05, 8'h09, 1, "R2");
    drive8(8'h85, 8'h84, 1, "R2");
    drive8(8'h64, 8'h32, 0, "R5");
    drive8(8'hE4, 8'h32, 1, "R5");
    drive8(8'h7F, 8'hFF, 1, "R5");
    drive8(8'h40, 8'h40, 0, "R5");
    drive8(8'h7F, 8'h01, 0, "R5");
    drive8(8'h7F, 8'h81, 0, "R5");
    drive8(8'h07, 8'h87, 0, "R8");
    drive8(8'h7F, 8'h7F, 1, "R8");
    drive8(8'h80, 8'h00, 0, "R7");
    drive8(8'h80, 8'h80, 1, "R7");
    drive8(8'h80, 8'h05, 0, "R7");
    drive8(8'h85, 8'h80, 1, "R7");
    for (int i = 0; i < 2; i++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          drive4(4'(x), 4'(y), bit'(i), "R1");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule